// File: doc/BRIEF.md
# DMA Stream Transfer Engine

This block is one DMA stream. It moves data from a source address range to a destination address range through a small burst FIFO. It works between a peripheral and memory in either direction, or from memory to memory. Software programs it through a word-addressed register port. The registers hold a control word, two base addresses, two current addresses and a transfer count. The engine issues single-beat reads and writes on a generic bus master port. Each beat holds its request until the slave acknowledges it.

When the memory-to-memory bit is clear, each burst waits for the peripheral request line. When the burst has been written out, the engine answers with a one-cycle acknowledge. The engine first fills a burst worth of destination-width words, gathering as many source beats as it needs, and then writes them out. Source bytes are packed or unpacked little-endian, so sizes may differ on the two sides. The count drops by one for each destination write. When it reaches zero, the stream stops, clears its own enable and raises a done flag. The address loading mode decides what happens on each new enable: the current addresses either reload from the bases or carry on from where they stopped.

Top module: `dma_stream`

## Requirements
- R1: After reset, every register reads zero, no bus beat is requested, and `done`, `cfg_err` and `per_ack` are low.
- R2: The control word at register index 0 has this layout: bit 0 enable, bit 1 direction (1 = peripheral is the destination), bit 2 memory-to-memory, bit 3 address mode (1 = incremental), bits 5:4 burst code, bits 7:6 source size code and bits 9:8 destination size code. Bits 31:10 read as zero whatever is written to them. The other registers are at these indexes: 1 source base, 2 destination base, 3 current source, 4 current destination, 5 count.
- R3: Burst codes 0, 1 and 2 mean 1, 4 and 8 destination words. Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. Each current address advances by its own side's byte width after each acknowledged beat. Destination data is the byte stream taken from consecutive source addresses, least significant byte first, with unused upper bytes zero.
- R4: When the memory-to-memory bit is clear, no burst starts while `per_req` is low. After every burst written in full, `per_ack` pulses high for exactly one cycle.
- R5: When the memory-to-memory bit is set, the engine ignores `per_req`, runs bursts back to back and never raises `per_ack`.
- R6: The count drops by one on each acknowledged destination write. When it reaches zero, the engine stops, raises `done` and clears the enable bit. Writing enable from 0 to 1 clears `done`.
- R7: With address mode 0, an enable transition from 0 to 1 reloads both current addresses from their bases.
- R8: With address mode 1, an enable transition leaves the current addresses as they are, so the transfer resumes from where it stopped.
- R9: `cfg_err` is high when any of these holds: a code is 3; the destination size code is 1 while the burst code is not 1; or, in a peripheral-destination transfer without memory-to-memory, the source size code differs from the burst code. While `cfg_err` is high, no new bus beat starts.
- R10: Clearing the enable bit lets the beat in flight complete. After that, no further beat is issued, and the current addresses and the count hold their values.
- R11: A bus request stays high with a stable address and write data until `bus_ack` is seen.
- R12: In each burst, every source read of that burst completes before the burst's first destination write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| per_req | input | 1 | Peripheral request for a burst |
| per_ack | output | 1 | One-cycle burst completion acknowledge |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | DW | Beat byte address |
| bus_size | output | 2 | Beat size code |
| bus_wdata | output | DW | Write data, least significant lanes used |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| bus_ack | input | 1 | Beat acknowledge |
| done | output | 1 | Count reached zero |
| cfg_err | output | 1 | Control word breaks a programming rule |

## Verification
Four behaviours are checked by properties on every cycle: the bus request holds until acknowledged, no beat starts under a bad configuration, `per_ack` is a single pulse that never appears in memory-to-memory mode, and the count steps down exactly once per write acknowledge. Reserved control bits reading zero and `done` rising only when idle at count zero are also checked each cycle. Only the bench scenarios can show the rest. These are the packed data and addresses of whole transfers in both directions, the reload and resume of the two address modes, the fill-before-drain order, and the values frozen in the registers after a mid-transfer disable.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int CTRL_W = 10;
    localparam int RIDX_W = 3;

    localparam logic [RIDX_W-1:0] RI_CTRL     = 3'd0;
    localparam logic [RIDX_W-1:0] RI_SRC_BASE = 3'd1;
    localparam logic [RIDX_W-1:0] RI_DST_BASE = 3'd2;
    localparam logic [RIDX_W-1:0] RI_SRC_CUR  = 3'd3;
    localparam logic [RIDX_W-1:0] RI_DST_CUR  = 3'd4;
    localparam logic [RIDX_W-1:0] RI_COUNT    = 3'd5;

    // first field is the most significant
    typedef struct packed {
        logic [1:0] dst_size;
        logic [1:0] src_size;
        logic [1:0] burst;
        logic       addr_inc;
        logic       m2m;
        logic       per_dst;
        logic       enable;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_FILL,
        ST_DRAIN,
        ST_ACK
    } xfer_state_e;

    function automatic logic [3:0] burst_words(input logic [1:0] code);
        case (code)
            2'd1:    return 4'd4;
            2'd2:    return 4'd8;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic cfg_bad(input ctrl_t c);
        logic bad;
        bad = (c.burst == 2'd3) || (c.src_size == 2'd3) || (c.dst_size == 2'd3);
        if (c.dst_size == 2'd1 && c.burst != 2'd1)
            bad = 1'b1;
        if (c.per_dst && !c.m2m && c.src_size != c.burst)
            bad = 1'b1;
        return bad;
    endfunction

endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;

    assign rdata = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[i] <= '0;
            else if (push && !flush && wr_ptr_q == AW'(i))
                mem_q[i] <= wdata;
        end
    end

endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [RIDX_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              src_step,
    input  logic              dst_step,
    input  logic              cnt_dec,
    input  logic              eng_stop,
    input  logic              done_set,
    output ctrl_t             ctrl,
    output logic [DW-1:0]     src_cur,
    output logic [DW-1:0]     dst_cur,
    output logic [CW-1:0]     count,
    output logic              start,
    output logic              done
);
    ctrl_t         ctrl_q;
    ctrl_t         ctrl_w;
    logic [DW-1:0] sbase_q, dbase_q, scur_q, dcur_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic [2:0]    sb, db;

    assign ctrl_w = ctrl_t'(wdata[CTRL_W-1:0]);
    assign start  = wr && (addr == RI_CTRL) && ctrl_w.enable && !ctrl_q.enable;
    assign sb     = size_bytes(ctrl_q.src_size);
    assign db     = size_bytes(ctrl_q.dst_size);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            sbase_q <= '0;
            dbase_q <= '0;
            scur_q  <= '0;
            dcur_q  <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            if (src_step) scur_q <= scur_q + DW'(sb);
            if (dst_step) dcur_q <= dcur_q + DW'(db);
            if (cnt_dec)  cnt_q  <= cnt_q - 1'b1;
            if (eng_stop) ctrl_q.enable <= 1'b0;
            if (done_set) done_q <= 1'b1;
            if (wr) begin
                case (addr)
                    RI_CTRL: begin
                        ctrl_q <= ctrl_w;
                        if (start) begin
                            done_q <= 1'b0;
                            if (!ctrl_w.addr_inc) begin
                                scur_q <= sbase_q;
                                dcur_q <= dbase_q;
                            end
                        end
                    end
                    RI_SRC_BASE: sbase_q <= wdata;
                    RI_DST_BASE: dbase_q <= wdata;
                    RI_SRC_CUR:  scur_q  <= wdata;
                    RI_DST_CUR:  dcur_q  <= wdata;
                    RI_COUNT:    cnt_q   <= wdata[CW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            RI_CTRL:     rdata = DW'(ctrl_q);
            RI_SRC_BASE: rdata = sbase_q;
            RI_DST_BASE: rdata = dbase_q;
            RI_SRC_CUR:  rdata = scur_q;
            RI_DST_CUR:  rdata = dcur_q;
            RI_COUNT:    rdata = DW'(cnt_q);
            default:     rdata = '0;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign src_cur = scur_q;
    assign dst_cur = dcur_q;
    assign count   = cnt_q;
    assign done    = done_q;

endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
    import dma_pkg::*;
#(
    parameter int DW         = 32,
    parameter int FIFO_DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          m2m,
    input  logic [1:0]    burst,
    input  logic [1:0]    src_size,
    input  logic [1:0]    dst_size,
    input  logic          cfg_err,
    input  logic          cnt_zero,
    input  logic          start,
    input  logic [DW-1:0] src_cur,
    input  logic [DW-1:0] dst_cur,
    input  logic          per_req,
    output logic          per_ack,
    output logic          bus_req,
    output logic          bus_we,
    output logic [DW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    output logic          src_step,
    output logic          dst_step,
    output logic          eng_stop,
    output logic          done_set
);
    localparam int PKW = 2 * DW;
    localparam int PCW = $clog2(PKW / 8) + 1;

    xfer_state_e   state_q, state_d;
    logic          busy_q, we_q;
    logic [DW-1:0] addr_q, wdata_q;
    logic [1:0]    size_q;
    logic [PKW-1:0] pk_q;
    logic [PCW-1:0] pk_cnt_q;
    logic [3:0]    nfill_q, ndrain_q;

    logic [3:0]    blen;
    logic [2:0]    sb, db;
    logic [DW-1:0] smask, dmask, fifo_rdata;
    logic          can_push, do_read, do_push, do_write, rd_done, burst_go;

    assign blen  = burst_words(burst);
    assign sb    = size_bytes(src_size);
    assign db    = size_bytes(dst_size);
    assign smask = {DW{1'b1}} >> (DW - 8 * int'(sb));
    assign dmask = {DW{1'b1}} >> (DW - 8 * int'(db));

    assign can_push = pk_cnt_q >= PCW'(db);
    assign do_read  = (state_q == ST_FILL) && !busy_q && en && !cfg_err
                      && (nfill_q != blen) && !can_push;
    assign do_push  = (state_q == ST_FILL) && !busy_q && en && !cfg_err
                      && (nfill_q != blen) && can_push;
    assign do_write = (state_q == ST_DRAIN) && !busy_q && en && !cfg_err
                      && !cnt_zero && (ndrain_q != blen);
    assign rd_done  = busy_q && bus_ack && !we_q;

    assign src_step = rd_done;
    assign dst_step = busy_q && bus_ack && we_q;

    dma_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (start),
        .push  (do_push),
        .wdata (pk_q[DW-1:0] & dmask),
        .pop   (do_write),
        .rdata (fifo_rdata)
    );

    always_comb begin
        state_d  = state_q;
        done_set = 1'b0;
        eng_stop = 1'b0;
        burst_go = 1'b0;
        case (state_q)
            ST_IDLE: if (en) state_d = ST_ARM;
            ST_ARM: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (cnt_zero) begin
                    done_set = 1'b1;
                    eng_stop = 1'b1;
                    state_d  = ST_IDLE;
                end else if (!cfg_err && (m2m || per_req)) begin
                    burst_go = 1'b1;
                    state_d  = ST_FILL;
                end
            end
            ST_FILL: begin
                if (!busy_q) begin
                    if (!en || cfg_err)       state_d = ST_IDLE;
                    else if (nfill_q == blen) state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!busy_q) begin
                    if (!en || cfg_err) begin
                        state_d = ST_IDLE;
                    end else if (ndrain_q == blen) begin
                        state_d = m2m ? ST_ARM : ST_ACK;
                    end else if (cnt_zero) begin
                        done_set = 1'b1;
                        eng_stop = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end
            end
            ST_ACK:  state_d = ST_ARM;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            busy_q   <= 1'b0;
            we_q     <= 1'b0;
            addr_q   <= '0;
            size_q   <= '0;
            wdata_q  <= '0;
            pk_q     <= '0;
            pk_cnt_q <= '0;
            nfill_q  <= '0;
            ndrain_q <= '0;
        end else begin
            state_q <= state_d;
            if (busy_q && bus_ack) busy_q <= 1'b0;
            if (burst_go) begin
                nfill_q  <= '0;
                ndrain_q <= '0;
            end
            if (rd_done) begin
                pk_q     <= pk_q | (PKW'(bus_rdata & smask) << (8 * int'(pk_cnt_q)));
                pk_cnt_q <= pk_cnt_q + PCW'(sb);
            end
            if (do_push) begin
                pk_q     <= pk_q >> (8 * int'(db));
                pk_cnt_q <= pk_cnt_q - PCW'(db);
                nfill_q  <= nfill_q + 1'b1;
            end
            if (do_read) begin
                busy_q <= 1'b1;
                we_q   <= 1'b0;
                addr_q <= src_cur;
                size_q <= src_size;
            end
            if (do_write) begin
                busy_q   <= 1'b1;
                we_q     <= 1'b1;
                addr_q   <= dst_cur;
                size_q   <= dst_size;
                wdata_q  <= fifo_rdata;
                ndrain_q <= ndrain_q + 1'b1;
            end
            if (start) begin
                pk_q     <= '0;
                pk_cnt_q <= '0;
            end
        end
    end

    assign per_ack   = (state_q == ST_ACK);
    assign bus_req   = busy_q;
    assign bus_we    = we_q;
    assign bus_addr  = addr_q;
    assign bus_size  = size_q;
    assign bus_wdata = wdata_q;

endmodule

// File: rtl/dma_stream.sv
module dma_stream
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              per_req,
    output logic              per_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ack,
    output logic              done,
    output logic              cfg_err
);
    localparam int FIFO_DEPTH = 8;

    ctrl_t         ctrl;
    logic [DW-1:0] src_cur, dst_cur;
    logic [CW-1:0] count;
    logic          start, src_step, dst_step, eng_stop, done_set;

    assign cfg_err = cfg_bad(ctrl);

    dma_regs #(.DW(DW), .CW(CW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .src_step (src_step),
        .dst_step (dst_step),
        .cnt_dec  (dst_step),
        .eng_stop (eng_stop),
        .done_set (done_set),
        .ctrl     (ctrl),
        .src_cur  (src_cur),
        .dst_cur  (dst_cur),
        .count    (count),
        .start    (start),
        .done     (done)
    );

    dma_xfer #(.DW(DW), .FIFO_DEPTH(FIFO_DEPTH)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.enable),
        .m2m       (ctrl.m2m),
        .burst     (ctrl.burst),
        .src_size  (ctrl.src_size),
        .dst_size  (ctrl.dst_size),
        .cfg_err   (cfg_err),
        .cnt_zero  (count == '0),
        .start     (start),
        .src_cur   (src_cur),
        .dst_cur   (dst_cur),
        .per_req   (per_req),
        .per_ack   (per_ack),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .src_step  (src_step),
        .dst_step  (dst_step),
        .eng_stop  (eng_stop),
        .done_set  (done_set)
    );

endmodule

// File: rtl/dma_stream_chk.sv
module dma_stream_chk #(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [DW-1:0] reg_rdata,
    input logic          bus_req,
    input logic          bus_we,
    input logic          bus_ack,
    input logic [DW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          per_ack,
    input logic          done,
    input logic          cfg_err,
    input logic          m2m,
    input logic [CW-1:0] count
);
    // R11
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));

    // R9
    no_start_on_bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !$past(cfg_err));

    // R5
    no_ack_in_m2m_chk: assert property (@(posedge clk) disable iff (rst)
        per_ack |-> !m2m);

    // R4
    ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        per_ack |=> !per_ack);

    // R6
    done_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (count == '0) && !bus_req);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && bus_ack && !reg_wr |=> count == $past(count) - 1'b1);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_addr == 3'd0 |-> reg_rdata[DW-1:10] == '0);

endmodule

bind dma_stream dma_stream_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .per_ack   (per_ack),
    .done      (done),
    .cfg_err   (cfg_err),
    .m2m       (ctrl.m2m),
    .count     (count)
);

// File: tb/dma_stream_test.sv
`timescale 1ns/1ps
module dma_stream_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic        per_ack;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        done, cfg_err;

    int checks = 0;
    int fails  = 0;
    int nreads = 0;
    int nwrites = 0;
    int nacks = 0;
    int reads_at_first_wr = -1;
    int lat = 0;
    int lat_cnt = 0;
    bit sb_on = 1'b0;

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic [1:0]  s;
    } exp_t;
    exp_t expq[$];

    dma_stream uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_ack(per_ack), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .done(done), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] mk_ctrl(input bit en, input bit pdst, input bit m2m,
                                            input bit inc, input logic [1:0] bl,
                                            input logic [1:0] ss, input logic [1:0] ds);
        return {22'd0, ds, ss, bl, inc, m2m, pdst, en};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus slave and scoreboard monitor
    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0;
            lat_cnt = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (lat_cnt < lat) begin
                lat_cnt++;
            end else begin
                lat_cnt = 0;
                bus_ack = 1'b1;
                if (!bus_we) begin
                    for (int i = 0; i < 4; i++)
                        bus_rdata[8*i +: 8] = mem_byte(bus_addr + 32'(i));
                    nreads++;
                end else begin
                    if (reads_at_first_wr < 0) reads_at_first_wr = nreads;
                    nwrites++;
                    if (sb_on) begin
                        if (expq.size() == 0) begin
                            check(1'b0, "R3 unexpected write", bus_addr, 0);
                        end else begin
                            exp_t e;
                            e = expq.pop_front();
                            check(bus_addr == e.a, "R3 write address", bus_addr, e.a);
                            check(bus_wdata == e.d, "R3 write data", bus_wdata, e.d);
                            check(bus_size == e.s, "R3 write size", 32'(bus_size), 32'(e.s));
                        end
                    end
                end
            end
        end
        if (!rst && per_ack) nacks++;
    end

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_run(input logic [31:0] s0, input logic [31:0] d0,
                              input int db, input logic [1:0] dsz, input int n);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.a = d0 + 32'(k * db);
            e.s = dsz;
            e.d = '0;
            for (int i = 0; i < db; i++)
                e.d[8*i +: 8] = mem_byte(s0 + 32'(k * db + i));
            expq.push_back(e);
        end
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, tag, 32'(done), 1);
        check(expq.size() == 0, "R3 all expected writes seen", expq.size(), 0);
    endtask

    task automatic setup(input logic [31:0] sb, input logic [31:0] db, input logic [31:0] cnt);
        wr_reg(3'd1, sb);
        wr_reg(3'd2, db);
        wr_reg(3'd5, cnt);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int w0, r0, a0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            rd_reg(3'(i), v);
            check(v == 0, "R1 register reset value", v, 0);
        end
        check(!bus_req && !done && !cfg_err && !per_ack, "R1 outputs after reset",
              {bus_req, done, cfg_err, per_ack}, 0);

        // R2 reserved bits
        wr_reg(3'd0, 32'hFFFF_FC00);
        rd_reg(3'd0, v);
        check(v == 0, "R2 reserved bits read zero", v, 0);
        wr_reg(3'd0, 32'hFFFF_FC3A);
        rd_reg(3'd0, v);
        check(v == 32'h3A, "R2 control fields kept", v, 32'h3A);
        wr_reg(3'd0, 0);

        // R5 R3 R6 R7: m2m 32->32, burst 4, count 6, per_req held low
        sb_on = 1'b1;
        setup(32'h1000, 32'h2000, 6);
        expect_run(32'h1000, 32'h2000, 4, 2'd2, 6);
        a0 = nacks;
        wr_reg(3'd0, mk_ctrl(1, 0, 1, 0, 2'd1, 2'd2, 2'd2));
        wait_done("R5 m2m runs without per_req, done rises");
        check(nacks == a0, "R5 no per_ack in m2m", nacks - a0, 0);
        rd_reg(3'd0, v);
        check(v[0] == 1'b0, "R6 enable cleared at zero count", v[0], 0);
        rd_reg(3'd5, v);
        check(v == 0, "R6 count at zero", v, 0);
        rd_reg(3'd3, v);
        check(v == 32'h1020, "R3 source advanced by two bursts", v, 32'h1020);
        rd_reg(3'd4, v);
        check(v == 32'h2018, "R3 destination advanced by six words", v, 32'h2018);

        // R8 incremental resume
        wr_reg(3'd5, 3);
        expect_run(32'h1020, 32'h2018, 4, 2'd2, 3);
        wr_reg(3'd0, mk_ctrl(1, 0, 1, 1, 2'd1, 2'd2, 2'd2));
        @(negedge clk);
        check(done == 1'b0, "R6 done cleared on enable", done, 0);
        wait_done("R8 resume run completes");
        rd_reg(3'd4, v);
        check(v == 32'h2024, "R8 destination continued", v, 32'h2024);

        // R7 wrapping reload
        wr_reg(3'd5, 2);
        expect_run(32'h1000, 32'h2000, 4, 2'd2, 2);
        wr_reg(3'd0, mk_ctrl(1, 0, 1, 0, 2'd1, 2'd2, 2'd2));
        wait_done("R7 reload run completes");
        rd_reg(3'd4, v);
        check(v == 32'h2008, "R7 destination restarted at base", v, 32'h2008);

        // R4 R12: peripheral source 8->32, burst 4, count 8
        setup(32'h5000, 32'h6000, 8);
        expect_run(32'h5000, 32'h6000, 4, 2'd2, 8);
        w0 = nwrites; r0 = nreads; a0 = nacks;
        lat = 1;
        wr_reg(3'd0, mk_ctrl(1, 0, 0, 0, 2'd1, 2'd0, 2'd2));
        repeat (20) @(negedge clk);
        check(nreads == r0 && nwrites == w0 && !bus_req, "R4 idle while per_req low",
              nreads - r0, 0);
        reads_at_first_wr = -1;
        per_req = 1'b1;
        wait_done("R4 peripheral source run completes");
        per_req = 1'b0;
        check(reads_at_first_wr - r0 == 16, "R12 burst filled before first write",
              reads_at_first_wr - r0, 16);
        check(nacks - a0 == 2, "R4 one per_ack per full burst", nacks - a0, 2);
        rd_reg(3'd3, v);
        check(v == 32'h5020, "R3 byte source advance", v, 32'h5020);

        // R4 R3: peripheral destination 16->8, burst 4, count 6
        setup(32'h7000, 32'h7800, 6);
        expect_run(32'h7000, 32'h7800, 1, 2'd0, 6);
        a0 = nacks;
        lat = 0;
        per_req = 1'b1;
        wr_reg(3'd0, mk_ctrl(1, 1, 0, 0, 2'd1, 2'd1, 2'd0));
        wait_done("R4 peripheral destination run completes");
        per_req = 1'b0;
        check(nacks - a0 == 1, "R4 no per_ack for cut burst", nacks - a0, 1);
        rd_reg(3'd3, v);
        check(v == 32'h7008, "R3 halfword source advance", v, 32'h7008);

        // R9 configuration rules
        setup(32'h100, 32'h200, 4);
        w0 = nwrites; r0 = nreads;
        wr_reg(3'd0, mk_ctrl(1, 0, 1, 0, 2'd0, 2'd1, 2'd1));
        repeat (30) @(negedge clk);
        check(cfg_err == 1'b1, "R9 dst size 1 with burst 0 flagged", cfg_err, 1);
        check(nreads == r0 && nwrites == w0, "R9 no beats under bad config", nreads - r0, 0);
        rd_reg(3'd5, v);
        check(v == 4, "R9 count untouched", v, 4);
        wr_reg(3'd0, mk_ctrl(0, 1, 0, 0, 2'd1, 2'd2, 2'd2));
        check(cfg_err == 1'b1, "R9 source size must match burst", cfg_err, 1);
        wr_reg(3'd0, mk_ctrl(0, 1, 0, 0, 2'd1, 2'd1, 2'd2));
        check(cfg_err == 1'b0, "R9 legal peripheral destination setup", cfg_err, 0);

        // R10 disable mid transfer
        sb_on = 1'b0;
        lat = 2;
        setup(32'h3000, 32'h4000, 200);
        w0 = nwrites; r0 = nreads;
        wr_reg(3'd0, mk_ctrl(1, 0, 1, 0, 2'd2, 2'd0, 2'd0));
        while (nwrites - w0 < 5) @(negedge clk);
        wr_reg(3'd0, mk_ctrl(0, 0, 1, 0, 2'd2, 2'd0, 2'd0));
        repeat (10) @(negedge clk);
        check(!bus_req, "R10 bus idle after disable", bus_req, 0);
        rd_reg(3'd4, v);
        check(v == 32'h4000 + 32'(nwrites - w0), "R10 destination matches writes done",
              v, 32'h4000 + 32'(nwrites - w0));
        rd_reg(3'd3, v2);
        check(v2 == 32'h3000 + 32'(nreads - r0), "R10 source matches reads done",
              v2, 32'h3000 + 32'(nreads - r0));
        rd_reg(3'd5, v);
        check(v == 32'(200 - (nwrites - w0)), "R10 count matches writes done",
              v, 32'(200 - (nwrites - w0)));
        repeat (20) @(negedge clk);
        rd_reg(3'd3, v);
        check(v == v2, "R10 source address holds", v, v2);
        check(!done, "R10 no done after disable", done, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule